// File: doc/BRIEF.md
# Embedded-Sync Video Capture into a Three-Slot Frame Ring

This block sits on an 8-bit digital video port that carries 4:2:2 samples with embedded synchronisation (ITU-R BT.656 style). There are no separate sync wires. Line and field timing come only from the four-byte timing reference codes in the byte stream. Beyond the data bus, the port uses a pixel clock and a sample-enable qualifier. The block keeps the luma bytes of the active picture and discards the chroma. It writes the luma as a linear image of `ACTIVE_W x ACTIVE_H` bytes (720x576 by default) through a byte-wide write port toward external memory.

The memory space is split into `NUM_SLOTS` frame slots, three by default. Capture moves to a new slot only at a frame boundary, which is the point where the field bit falls from 1 to 0. A frame that has filled its slot is queued for a downstream consumer. The consumer is given the oldest queued frame as a held slot index and base address, and later releases it. Capture keeps cycling through the slots the consumer does not hold. Only when every slot is either queued or held is an incoming frame dropped, and a sticky overflow flag records that this happened.

Top module: `vcap_bt656_capture`

## Requirements
- R1: A timing code is recognised only as the four qualified bytes FF, 00, 00, XY. In XY, bit 6 is the field bit F, bit 5 the blanking bit V and bit 4 the position bit H (0 = start of active video, 1 = end). Any other byte pattern, such as FF 00 10 80, has no effect on timing.
- R2: After a start-of-active code with V = 0, the next 2*ACTIVE_W qualified bytes are the line, ordered Cb, Y, Cr, Y. Only the Y bytes (odd positions counted from 0) reach the write port. Lines whose code has V = 1 store nothing.
- R3: A frame boundary is a timing code with F = 0 whose preceding timing code had F = 1. The field bit reads as 0 after reset. No byte is written before the first boundary after reset.
- R4: Within a frame, the n-th stored luma byte goes to address slot*ACTIVE_W*ACTIVE_H + n, with n starting at 0 at each boundary. At most ACTIVE_W*ACTIVE_H bytes are stored per frame, and any further luma bytes are ignored.
- R5: A luma byte sampled on clock edge k shows up on the write port (write enable, address, data) during the cycle after edge k+1. The write enable is high for exactly one cycle per stored byte.
- R6: At a boundary, the slot being filled is queued as ready if it holds exactly ACTIVE_W*ACTIVE_H bytes. Otherwise it goes back to free and is never announced.
- R7: While the consumer holds a frame, `frm_rdy` is high and `frm_slot`/`frm_base` give its slot and base address, and they stay stable. When nothing is held and the queue is not empty, the oldest queued slot becomes held on the next clock edge.
- R8: A `frm_release` pulse while a frame is held frees that slot at that edge. The next queued frame can become held no sooner than the following edge. A release while nothing is held has no effect.
- R9: At a boundary, the new fill slot is the lowest-indexed free slot, counted after this boundary's completion has been taken into account. It is never a held or queued slot.
- R10: If no slot is free at a boundary, the whole incoming frame is dropped, with no writes until the next boundary. `ovf_flag` is set and stays set until reset.
- R11: After reset, `mem_we`, `frm_rdy` and `ovf_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Sample enable; a byte counts only when high |
| pix_data | input | 8 | Video byte stream with embedded timing codes |
| mem_we | output | 1 | Write strobe toward frame memory |
| mem_addr | output | AW | Byte address of the write (slot base plus offset) |
| mem_data | output | 8 | Luma byte to store |
| frm_rdy | output | 1 | A completed frame is held by the consumer |
| frm_slot | output | SW | Slot index of the held frame |
| frm_base | output | AW | Base address of the held slot |
| frm_release | input | 1 | Consumer pulse returning the held slot |
| ovf_flag | output | 1 | Sticky: a frame was dropped for lack of a free slot |

## Verification
The stimulus uses a 4x4 frame so that whole frame sequences run quickly. Each line's blanking gap carries a decoy pattern, FF 00 10 80. A parser that matched on too few bytes would open a bogus active window and produce extra writes. Frames are sent with extra active lines, which a design without a per-frame byte limit would spill into the next slot. Frames are also sent with too few lines, which a design that announced every frame would hand to the consumer. The bench drives the consumer so that all slots fill up, and checks that the incoming frame is dropped rather than written over the held slot. It also releases a slot when none is held, which a design without a held-slot guard would turn into a freed or duplicated slot.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

   typedef enum logic [1:0] {
      SL_FREE  = 2'd0,
      SL_FILL  = 2'd1,
      SL_READY = 2'd2,
      SL_HELD  = 2'd3
   } slot_st_t;

   localparam logic [7:0] TRS_LEAD = 8'hFF;
   localparam logic [7:0] TRS_ZERO = 8'h00;

   localparam int XY_F = 6;
   localparam int XY_V = 5;
   localparam int XY_H = 4;

endpackage

// File: rtl/vcap_trs_parser.sv
module vcap_trs_parser
   import vcap_pkg::*;
#(
   parameter int ACTIVE_W = 720,
   parameter bit Y_ODD    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp_en,
   input  logic [7:0] din,
   output logic       luma_we,
   output logic [7:0] luma,
   output logic       frame_start
);

   localparam int LINE_BYTES = 2 * ACTIVE_W;
   localparam int BW = (LINE_BYTES > 2) ? $clog2(LINE_BYTES) : 1;

   logic [7:0]    h1, h2, h3;
   logic          last_f;
   logic          in_act;
   logic [BW-1:0] bcnt;
   logic          trs_hit;
   logic          is_y;

   assign trs_hit = smp_en && (h3 == TRS_LEAD) && (h2 == TRS_ZERO) && (h1 == TRS_ZERO);

   generate
      if (Y_ODD) begin : g_y_odd
         assign is_y = bcnt[0];
      end else begin : g_y_even
         assign is_y = ~bcnt[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h1          <= '0;
         h2          <= '0;
         h3          <= '0;
         last_f      <= 1'b0;
         in_act      <= 1'b0;
         bcnt        <= '0;
         luma_we     <= 1'b0;
         luma        <= '0;
         frame_start <= 1'b0;
      end else begin
         luma_we     <= 1'b0;
         frame_start <= 1'b0;
         if (smp_en) begin
            h3 <= h2;
            h2 <= h1;
            h1 <= din;
         end
         if (trs_hit) begin
            last_f      <= din[XY_F];
            frame_start <= last_f & ~din[XY_F];
            if (!din[XY_H] && !din[XY_V]) begin
               in_act <= 1'b1;
               bcnt   <= '0;
            end else begin
               in_act <= 1'b0;
            end
         end else if (smp_en && in_act) begin
            luma_we <= is_y;
            luma    <= din;
            bcnt    <= bcnt + 1'b1;
            if (bcnt == BW'(LINE_BYTES - 1)) begin
               in_act <= 1'b0;
            end
         end
      end
   end

   // R2: a luma strobe only ever follows a cycle inside the active window
   p_luma_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      luma_we |-> $past(in_act));

   // R3: a boundary and a luma strobe come from different bytes
   p_fs_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> !luma_we);

endmodule

// File: rtl/vcap_wr_addr.sv
module vcap_wr_addr #(
   parameter int FRAME_PIX = 414720,
   parameter int NUM_SLOTS = 3,
   parameter int AW        = 21,
   parameter int SW        = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          luma_we,
   input  logic [7:0]    luma,
   input  logic          frame_start,
   input  logic          cur_v,
   input  logic [SW-1:0] cur_slot,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_data,
   output logic          frame_full
);

   localparam int PW = $clog2(FRAME_PIX + 1);

   logic [PW-1:0] pcnt;
   logic [AW-1:0] base_tab [NUM_SLOTS];

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_base
         assign base_tab[s] = AW'(s * FRAME_PIX);
      end
   endgenerate

   assign frame_full = (pcnt == PW'(FRAME_PIX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt     <= '0;
         mem_we   <= 1'b0;
         mem_addr <= '0;
         mem_data <= '0;
      end else begin
         mem_we <= 1'b0;
         if (frame_start) begin
            pcnt <= '0;
         end else if (luma_we && cur_v && (pcnt < PW'(FRAME_PIX))) begin
            mem_we   <= 1'b1;
            mem_addr <= base_tab[cur_slot] + AW'(pcnt);
            mem_data <= luma;
            pcnt     <= pcnt + 1'b1;
         end
      end
   end

   // R3: a write only happens while a slot was owned by capture
   p_we_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(cur_v));

   // R4: the per-frame offset restarts at every boundary
   p_cnt_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (pcnt == '0));

endmodule

// File: rtl/vcap_slot_ring.sv
module vcap_slot_ring
   import vcap_pkg::*;
#(
   parameter int NUM_SLOTS = 3,
   parameter int SW        = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   input  logic          frame_full,
   input  logic          release_i,
   output logic          cur_v,
   output logic [SW-1:0] cur_slot,
   output logic          held_v,
   output logic [SW-1:0] held_slot,
   output logic          ovf
);

   localparam int QW = $clog2(NUM_SLOTS + 1);

   slot_st_t      st   [NUM_SLOTS];
   slot_st_t      st_n [NUM_SLOTS];
   logic [SW-1:0] rq   [NUM_SLOTS];
   logic [SW-1:0] rq_n [NUM_SLOTS];
   logic [QW-1:0] rq_cnt, rq_cnt_n;
   logic          cur_v_n, held_v_n, ovf_n;
   logic [SW-1:0] cur_n, held_n, pick;
   logic          pick_v;

   always_comb begin
      st_n     = st;
      rq_n     = rq;
      rq_cnt_n = rq_cnt;
      cur_v_n  = cur_v;
      cur_n    = cur_slot;
      held_v_n = held_v;
      held_n   = held_slot;
      ovf_n    = ovf;
      pick_v   = 1'b0;
      pick     = '0;

      if (release_i && held_v) begin
         st_n[held_slot] = SL_FREE;
         held_v_n        = 1'b0;
      end else if (!held_v && (rq_cnt != '0)) begin
         st_n[rq[0]] = SL_HELD;
         held_v_n    = 1'b1;
         held_n      = rq[0];
         for (int i = 0; i < NUM_SLOTS - 1; i++) begin
            rq_n[i] = rq[i+1];
         end
         rq_n[NUM_SLOTS-1] = '0;
         rq_cnt_n          = rq_cnt - QW'(1);
      end

      if (frame_start) begin
         if (cur_v) begin
            if (frame_full) begin
               st_n[cur_slot]  = SL_READY;
               rq_n[rq_cnt_n]  = cur_slot;
               rq_cnt_n        = rq_cnt_n + QW'(1);
            end else begin
               st_n[cur_slot] = SL_FREE;
            end
         end
         for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (st_n[i] == SL_FREE) begin
               pick_v = 1'b1;
               pick   = SW'(i);
            end
         end
         if (pick_v) begin
            st_n[pick] = SL_FILL;
            cur_v_n    = 1'b1;
            cur_n      = pick;
         end else begin
            cur_v_n = 1'b0;
            ovf_n   = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SLOTS; i++) begin
            st[i] <= SL_FREE;
            rq[i] <= '0;
         end
         rq_cnt    <= '0;
         cur_v     <= 1'b0;
         cur_slot  <= '0;
         held_v    <= 1'b0;
         held_slot <= '0;
         ovf       <= 1'b0;
      end else begin
         st        <= st_n;
         rq        <= rq_n;
         rq_cnt    <= rq_cnt_n;
         cur_v     <= cur_v_n;
         cur_slot  <= cur_n;
         held_v    <= held_v_n;
         held_slot <= held_n;
         ovf       <= ovf_n;
      end
   end

   // R7: a held frame keeps its slot until released
   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (held_v && !release_i) |=> (held_v && $stable(held_slot)));

   // R8: a release of a held frame frees it at that edge
   p_release_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (release_i && held_v) |=> !held_v);

   // R9: capture never fills the slot the consumer holds
   p_fill_not_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_v && held_v) |-> (cur_slot != held_slot));

   // R10: the overflow flag never clears once set
   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

endmodule

// File: rtl/vcap_bt656_capture.sv
module vcap_bt656_capture #(
   parameter int  ACTIVE_W  = 720,
   parameter int  ACTIVE_H  = 576,
   parameter int  NUM_SLOTS = 3,
   parameter bit  Y_ODD     = 1'b1,
   localparam int FRAME_PIX = ACTIVE_W * ACTIVE_H,
   localparam int AW        = $clog2(NUM_SLOTS * FRAME_PIX),
   localparam int SW        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_en,
   input  logic [7:0]    pix_data,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_data,
   output logic          frm_rdy,
   output logic [SW-1:0] frm_slot,
   output logic [AW-1:0] frm_base,
   input  logic          frm_release,
   output logic          ovf_flag
);

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("NUM_SLOTS must be at least 2");
      end
      if (ACTIVE_W < 1 || ACTIVE_H < 1) begin : g_bad_size
         $error("ACTIVE_W and ACTIVE_H must be positive");
      end
   endgenerate

   logic          luma_we;
   logic [7:0]    luma;
   logic          frame_start;
   logic          frame_full;
   logic          cur_v;
   logic [SW-1:0] cur_slot;
   logic          held_v;
   logic [SW-1:0] held_slot;

   vcap_trs_parser #(
      .ACTIVE_W (ACTIVE_W),
      .Y_ODD    (Y_ODD)
   ) u_parser (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_en      (pix_en),
      .din         (pix_data),
      .luma_we     (luma_we),
      .luma        (luma),
      .frame_start (frame_start)
   );

   vcap_wr_addr #(
      .FRAME_PIX (FRAME_PIX),
      .NUM_SLOTS (NUM_SLOTS),
      .AW        (AW),
      .SW        (SW)
   ) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .luma_we     (luma_we),
      .luma        (luma),
      .frame_start (frame_start),
      .cur_v       (cur_v),
      .cur_slot    (cur_slot),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_data    (mem_data),
      .frame_full  (frame_full)
   );

   vcap_slot_ring #(
      .NUM_SLOTS (NUM_SLOTS),
      .SW        (SW)
   ) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .frame_full  (frame_full),
      .release_i   (frm_release),
      .cur_v       (cur_v),
      .cur_slot    (cur_slot),
      .held_v      (held_v),
      .held_slot   (held_slot),
      .ovf         (ovf_flag)
   );

   assign frm_rdy  = held_v;
   assign frm_slot = held_slot;
   assign frm_base = AW'(held_slot) * AW'(FRAME_PIX);

endmodule

// File: tb/vcap_bt656_capture_tb.sv
`timescale 1ns/1ps
module vcap_bt656_capture_tb;

   localparam int W  = 4;
   localparam int H  = 4;
   localparam int NS = 3;
   localparam int FP = W * H;
   localparam int AW = $clog2(NS * FP);
   localparam int SW = $clog2(NS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pix_en = 1'b0;
   logic [7:0]    pix_data = 8'h00;
   logic          frm_release = 1'b0;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_data;
   logic          frm_rdy;
   logic [SW-1:0] frm_slot;
   logic [AW-1:0] frm_base;
   logic          ovf_flag;

   always #4 clk = ~clk;

   vcap_bt656_capture #(.ACTIVE_W(W), .ACTIVE_H(H), .NUM_SLOTS(NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_data(pix_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
      .frm_rdy(frm_rdy), .frm_slot(frm_slot), .frm_base(frm_base),
      .frm_release(frm_release), .ovf_flag(ovf_flag));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit cmp_on = 1'b0;

   task automatic chk_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // stimulus tags seen by the reference model
   bit t_luma = 1'b0;
   bit t_fs   = 1'b0;
   bit tb_last_f = 1'b0;
   int gap_cnt = 0;
   logic [7:0] y_next = 8'h10;
   int c_next = 0;

   // reference model state
   bit   m1_luma, m1_fs;
   logic [7:0] m1_data;
   bit   e_we;
   int   e_addr, e_data;
   int   m_cnt;
   bit   m_cur_v;
   int   m_cur;
   int   m_st [NS];
   int   rq [$];
   bit   m_held_v;
   int   m_held;
   bit   m_ovf;

   always @(posedge clk) begin : mdl
      bit full;
      int pick;
      if (!rst_n) begin
         m1_luma = 0; m1_fs = 0; m1_data = 0; e_we = 0; e_addr = 0; e_data = 0;
         m_cnt = 0; m_cur_v = 0; m_cur = 0; m_held_v = 0; m_held = 0; m_ovf = 0;
         for (int i = 0; i < NS; i++) m_st[i] = 0;
         rq.delete();
      end else begin
         full = (m_cnt == FP);
         e_we = 0;
         if (m1_fs) m_cnt = 0;
         else if (m1_luma && m_cur_v && m_cnt < FP) begin
            e_we = 1; e_addr = m_cur * FP + m_cnt; e_data = m1_data; m_cnt++;
         end
         if (frm_release && m_held_v) begin
            m_st[m_held] = 0; m_held_v = 0;
         end else if (!m_held_v && rq.size() > 0) begin
            m_held = rq.pop_front(); m_st[m_held] = 3; m_held_v = 1;
         end
         if (m1_fs) begin
            if (m_cur_v) begin
               if (full) begin m_st[m_cur] = 2; rq.push_back(m_cur); end
               else m_st[m_cur] = 0;
            end
            pick = -1;
            for (int i = 0; i < NS; i++) if (m_st[i] == 0 && pick < 0) pick = i;
            if (pick >= 0) begin m_st[pick] = 1; m_cur_v = 1; m_cur = pick; end
            else begin m_cur_v = 0; m_ovf = 1; end
         end
         m1_luma = pix_en && t_luma;
         m1_fs   = pix_en && t_fs;
         m1_data = pix_data;
      end
   end

   // observed writes
   int wr_seen = 0;
   int first_addr = -1;
   int bad_luma = 0;

   always @(negedge clk) begin
      if (cmp_on) begin
         chk_eq("R5 mem_we timing", int'(mem_we), int'(e_we));
         if (mem_we && e_we) begin
            chk_eq("R4 mem_addr", int'(mem_addr), e_addr);
            chk_eq("R2 mem_data", int'(mem_data), e_data);
         end
         chk_eq("R7 frm_rdy", int'(frm_rdy), int'(m_held_v));
         if (m_held_v) begin
            chk_eq("R7 frm_slot", int'(frm_slot), m_held);
            chk_eq("R7 frm_base", int'(frm_base), m_held * FP);
         end
         chk_eq("R10 ovf_flag", int'(ovf_flag), int'(m_ovf));
         if (mem_we) begin
            wr_seen++;
            if (wr_seen == 1) first_addr = int'(mem_addr);
            if (mem_data >= 8'h80) bad_luma++;
         end
      end
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pix_en = 1'b0; t_luma = 0; t_fs = 0; frm_release = 1'b0;
      end
   endtask

   task automatic put(input logic [7:0] b, input bit is_luma, input bit is_fs);
      @(negedge clk);
      pix_en = 1'b1; pix_data = b; t_luma = is_luma; t_fs = is_fs; frm_release = 1'b0;
      gap_cnt++;
      if (gap_cnt % 5 == 0) idle(1);
   endtask

   task automatic send_code(input bit f, input bit v, input bit h);
      logic [7:0] xy;
      bit fs;
      xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
      fs = tb_last_f && !f;
      tb_last_f = f;
      put(8'hFF, 0, 0); put(8'h00, 0, 0); put(8'h00, 0, 0); put(xy, 0, fs);
   endtask

   task automatic send_line(input bit f, input bit v);
      send_code(f, v, 1'b1);
      // decoy for R1: not a timing code
      put(8'hFF, 0, 0); put(8'h00, 0, 0); put(8'h10, 0, 0); put(8'h80, 0, 0);
      send_code(f, v, 1'b0);
      for (int i = 0; i < 2 * W; i++) begin
         if (v) put((i % 2 == 1) ? 8'h10 : 8'h80, 0, 0);
         else if (i % 2 == 0) begin
            put(8'hC0 + 8'(c_next % 16), 0, 0); c_next++;
         end else begin
            put(y_next, 1, 0);
            y_next = (y_next == 8'h7F) ? 8'h10 : y_next + 8'h01;
         end
      end
   endtask

   task automatic send_field(input bit f, input int nact);
      send_line(f, 1'b1);
      for (int i = 0; i < nact; i++) send_line(f, 1'b0);
   endtask

   task automatic send_frame(input int n0, input int n1);
      send_field(1'b0, n0);
      send_field(1'b1, n1);
      idle(4);
   endtask

   task automatic pulse_release();
      @(negedge clk);
      pix_en = 1'b0; t_luma = 0; t_fs = 0; frm_release = 1'b1;
      idle(4);
   endtask

   task automatic clear_obs();
      wr_seen = 0; first_addr = -1;
   endtask

   initial begin
      idle(5);
      @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      chk_eq("R11 mem_we after reset", int'(mem_we), 0);
      chk_eq("R11 frm_rdy after reset", int'(frm_rdy), 0);
      chk_eq("R11 ovf_flag after reset", int'(ovf_flag), 0);
      cmp_on = 1'b1;

      // preamble field F=1: nothing stored before first boundary (R3)
      clear_obs();
      send_field(1'b1, 2);
      idle(4);
      chk_eq("R3 writes before first boundary", wr_seen, 0);

      // frame A into slot 0
      clear_obs();
      send_frame(2, 2);
      chk_eq("R1/R4 writes in frame A", wr_seen, FP);
      chk_eq("R9 frame A slot base", first_addr, 0);
      chk_eq("R2 only luma stored", bad_luma, 0);
      chk_eq("R6 frame A not yet announced", int'(frm_rdy), 0);

      // frame B into slot 1, A announced
      clear_obs();
      send_frame(2, 2);
      chk_eq("R6 frame A announced", int'(frm_rdy), 1);
      chk_eq("R7 held slot is 0", int'(frm_slot), 0);
      chk_eq("R9 frame B slot base", first_addr, FP);

      // frame C into slot 2
      clear_obs();
      send_frame(2, 2);
      chk_eq("R9 frame C slot base", first_addr, 2 * FP);
      chk_eq("R7 slot 0 still held", int'(frm_slot), 0);

      // frame D: no free slot, dropped
      clear_obs();
      send_frame(2, 2);
      chk_eq("R10 dropped frame writes", wr_seen, 0);
      chk_eq("R10 overflow set", int'(ovf_flag), 1);

      pulse_release();
      chk_eq("R8 next queued frame held", int'(frm_slot), 1);
      chk_eq("R8 base of held slot", int'(frm_base), FP);

      // frame E with extra lines into slot 0
      clear_obs();
      send_frame(3, 3);
      chk_eq("R4 write limit per frame", wr_seen, FP);
      chk_eq("R9 lowest free slot after drop", first_addr, 0);

      pulse_release();
      chk_eq("R8 slot 2 now held", int'(frm_slot), 2);

      // frame F partial into slot 1
      clear_obs();
      send_frame(1, 1);
      chk_eq("R6 partial frame writes", wr_seen, FP / 2);
      chk_eq("R9 frame F slot base", first_addr, FP);

      // frame G: slot 1 reused since F was not complete
      clear_obs();
      send_frame(2, 2);
      chk_eq("R6 partial slot reused", first_addr, FP);
      chk_eq("R10 overflow still set", int'(ovf_flag), 1);

      pulse_release();
      chk_eq("R7 oldest queued frame next", int'(frm_slot), 0);
      pulse_release();
      chk_eq("R6 partial frame never queued", int'(frm_rdy), 0);
      pulse_release();
      chk_eq("R8 stray release ignored", int'(frm_rdy), 0);
      chk_eq("R8 stray release keeps ovf", int'(ovf_flag), 1);

      // boundary completes G
      send_code(1'b0, 1'b1, 1'b1);
      idle(5);
      chk_eq("R6 frame G announced", int'(frm_rdy), 1);
      chk_eq("R7 frame G slot", int'(frm_slot), 1);

      cmp_on = 1'b0;
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule